// File: doc/BRIEF.md
# Paged Data-Pointer Address Generator

This block holds a set of selectable 16-bit data pointers, each paired with an 8-bit page byte. Together they form 24-bit addresses for a processor core that uses a paged memory model. The core chooses the active pair with a select register. It loads any byte of the active pair through a one-byte write command, and it steps the active pointer up or down by one. Page bytes never take part in that arithmetic.

Two addresses are presented at all times. The external-data address is the active page byte placed above the active pointer. The indexed code address serves jump-through-table and code-constant fetches. It adds the zero-extended accumulator to the active pointer, keeps the 16-bit result within the current 64 KB bank, and takes bits 23:16 from the address of the instruction now executing. The page byte plays no part in it.

Top module: `xptr_addr_gen`

## Requirements
- R1: While reset is low, and at the first clock after its release, every pointer and every page byte reads zero and the select register reads pair 0.
- R2: When `sel_wr_i` is high at a clock edge, `sel_o` takes `sel_i` after that edge. All pointer and page outputs then show the newly selected pair.
- R3: `cmd_i` code 1 writes `wdata_i` into pointer bits 7:0, code 2 writes pointer bits 15:8, and code 3 writes the page byte. Each acts only on the pair selected before the edge and leaves the other bytes alone.
- R4: `cmd_i` code 4 adds one to the selected pointer modulo 2^16. At FFFFh it wraps to 0000h and the page byte does not change.
- R5: `cmd_i` code 5 subtracts one from the selected pointer modulo 2^16. At 0000h it wraps to FFFFh and the page byte does not change.
- R6: `data_addr_o` equals the selected page byte in bits 23:16 and the selected pointer in bits 15:0.
- R7: `code_addr_o[23:16]` equals `exec_addr_i[23:16]`. `code_addr_o[15:0]` equals (selected pointer + zero-extended `acc_i`) modulo 2^16, with no carry into bits 23:16.
- R8: `cmd_i` codes 0, 6 and 7 leave every pointer and page byte unchanged.
- R9: A command never alters a pair other than the one selected when it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_wr_i | input | 1 | Load the pair select register |
| sel_i | input | 2 | New pair index |
| cmd_i | input | 3 | Pointer command code |
| wdata_i | input | 8 | Byte for write commands |
| acc_i | input | 8 | Accumulator for indexed code addressing |
| exec_addr_i | input | 24 | Address of the executing instruction |
| sel_o | output | 2 | Active pair index |
| ptr_o | output | 16 | Active pointer |
| page_o | output | 8 | Active page byte |
| data_addr_o | output | 24 | External-data address |
| code_addr_o | output | 24 | Indexed code address |

## Verification
The bench builds the block with its default values: four pairs and 8-bit bytes. With these, the 2-bit select covers every pair. Random selection exposes any change that leaks onto a pair that was not addressed. The 16-bit pointers are also small enough for directed cases to reach both the FFFFh and 0000h wrap points, and an accumulator sum that crosses the bank boundary.

// File: rtl/xptr_pkg.sv
package xptr_pkg;
    typedef enum logic [2:0] {
        XP_NOP     = 3'd0,
        XP_WR_LO   = 3'd1,
        XP_WR_HI   = 3'd2,
        XP_WR_PAGE = 3'd3,
        XP_INC     = 3'd4,
        XP_DEC     = 3'd5
    } xp_cmd_e;
endpackage

// File: rtl/xptr_bank.sv
module xptr_bank
    import xptr_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int BYTE_W    = 8,
    localparam int SEL_W    = $clog2(NUM_PAIRS),
    localparam int PTR_W    = 2 * BYTE_W
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 sel_wr_i,
    input  logic [SEL_W-1:0]                     sel_i,
    input  logic [2:0]                           cmd_i,
    input  logic [BYTE_W-1:0]                    wdata_i,
    output logic [SEL_W-1:0]                     sel_o,
    output logic [NUM_PAIRS-1:0][PTR_W-1:0]      ptr_o,
    output logic [NUM_PAIRS-1:0][BYTE_W-1:0]     page_o
);
    typedef struct packed {
        logic [SEL_W-1:0]                 sel;
        logic [NUM_PAIRS-1:0][PTR_W-1:0]  ptr;
        logic [NUM_PAIRS-1:0][BYTE_W-1:0] pg;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr_i) st_d.sel = sel_i;
        case (cmd_i)
            XP_WR_LO:   st_d.ptr[st_q.sel][BYTE_W-1:0]     = wdata_i;
            XP_WR_HI:   st_d.ptr[st_q.sel][PTR_W-1:BYTE_W] = wdata_i;
            XP_WR_PAGE: st_d.pg[st_q.sel]                  = wdata_i;
            XP_INC:     st_d.ptr[st_q.sel] = st_q.ptr[st_q.sel] + PTR_W'(1);
            XP_DEC:     st_d.ptr[st_q.sel] = st_q.ptr[st_q.sel] - PTR_W'(1);
            default:    ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_o  = st_q.sel;
    assign ptr_o  = st_q.ptr;
    assign page_o = st_q.pg;

    assert_sel_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_wr_i |=> (st_q.sel == $past(sel_i)));

    assert_inc_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == XP_INC) |=>
        (st_q.ptr[$past(st_q.sel)] == PTR_W'($past(st_q.ptr[st_q.sel]) + 1)));

    assert_dec_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == XP_DEC) |=>
        (st_q.ptr[$past(st_q.sel)] == PTR_W'($past(st_q.ptr[st_q.sel]) - 1)));

    assert_page_no_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == XP_INC || cmd_i == XP_DEC) |=> $stable(st_q.pg));

    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == XP_NOP || cmd_i == 3'd6 || cmd_i == 3'd7) |=>
        ($stable(st_q.ptr) && $stable(st_q.pg)));
endmodule

// File: rtl/xptr_agen.sv
module xptr_agen #(
    parameter int NUM_PAIRS = 4,
    parameter int BYTE_W    = 8,
    localparam int SEL_W    = $clog2(NUM_PAIRS),
    localparam int PTR_W    = 2 * BYTE_W,
    localparam int ADDR_W   = 3 * BYTE_W
) (
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [NUM_PAIRS-1:0][PTR_W-1:0]  ptr_i,
    input  logic [NUM_PAIRS-1:0][BYTE_W-1:0] page_i,
    input  logic [BYTE_W-1:0]                acc_i,
    input  logic [ADDR_W-1:0]                exec_addr_i,
    output logic [PTR_W-1:0]                 ptr_o,
    output logic [BYTE_W-1:0]                page_o,
    output logic [ADDR_W-1:0]                data_addr_o,
    output logic [ADDR_W-1:0]                code_addr_o
);
    logic [NUM_PAIRS-1:0][PTR_W-1:0]  ptr_m;
    logic [NUM_PAIRS-1:0][BYTE_W-1:0] page_m;
    logic [PTR_W-1:0]                 ptr_sel;
    logic [BYTE_W-1:0]                page_sel;
    logic [PTR_W-1:0]                 idx_sum;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_mask
        assign ptr_m[g]  = (sel_i == SEL_W'(g)) ? ptr_i[g]  : '0;
        assign page_m[g] = (sel_i == SEL_W'(g)) ? page_i[g] : '0;
    end

    always_comb begin
        ptr_sel  = '0;
        page_sel = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            ptr_sel  = ptr_sel  | ptr_m[i];
            page_sel = page_sel | page_m[i];
        end
    end

    // 16-bit sum: wraps inside the bank, never carries upward.
    assign idx_sum     = ptr_sel + {{BYTE_W{1'b0}}, acc_i};
    assign ptr_o       = ptr_sel;
    assign page_o      = page_sel;
    assign data_addr_o = {page_sel, ptr_sel};
    assign code_addr_o = {exec_addr_i[ADDR_W-1:PTR_W], idx_sum};
endmodule

// File: rtl/xptr_addr_gen.sv
module xptr_addr_gen #(
    parameter int NUM_PAIRS = 4,
    parameter int BYTE_W    = 8,
    localparam int SEL_W    = $clog2(NUM_PAIRS),
    localparam int PTR_W    = 2 * BYTE_W,
    localparam int ADDR_W   = 3 * BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_wr_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [2:0]        cmd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [BYTE_W-1:0] page_o,
    output logic [ADDR_W-1:0] data_addr_o,
    output logic [ADDR_W-1:0] code_addr_o
);
    logic [NUM_PAIRS-1:0][PTR_W-1:0]  all_ptr;
    logic [NUM_PAIRS-1:0][BYTE_W-1:0] all_page;

    xptr_bank #(.NUM_PAIRS(NUM_PAIRS), .BYTE_W(BYTE_W)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_wr_i (sel_wr_i),
        .sel_i    (sel_i),
        .cmd_i    (cmd_i),
        .wdata_i  (wdata_i),
        .sel_o    (sel_o),
        .ptr_o    (all_ptr),
        .page_o   (all_page)
    );

    xptr_agen #(.NUM_PAIRS(NUM_PAIRS), .BYTE_W(BYTE_W)) u_agen (
        .sel_i       (sel_o),
        .ptr_i       (all_ptr),
        .page_i      (all_page),
        .acc_i       (acc_i),
        .exec_addr_i (exec_addr_i),
        .ptr_o       (ptr_o),
        .page_o      (page_o),
        .data_addr_o (data_addr_o),
        .code_addr_o (code_addr_o)
    );
endmodule

// File: tb/xptr_addr_gen_tb.sv
module xptr_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [1:0]  sel = '0;
    logic [2:0]  cmd = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  acc = '0;
    logic [23:0] exec_addr = '0;
    logic [1:0]  sel_o;
    logic [15:0] ptr_o;
    logic [7:0]  page_o;
    logic [23:0] data_addr, code_addr;

    int unsigned n_chk = 0, n_fail = 0;
    logic [15:0] m_ptr [4];
    logic [7:0]  m_pg  [4];
    logic [1:0]  m_sel;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    xptr_addr_gen u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sel_wr_i(sel_wr), .sel_i(sel),
        .cmd_i(cmd), .wdata_i(wdata), .acc_i(acc), .exec_addr_i(exec_addr),
        .sel_o(sel_o), .ptr_o(ptr_o), .page_o(page_o),
        .data_addr_o(data_addr), .code_addr_o(code_addr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_code(logic [7:0] a, logic [23:0] ex);
        logic [15:0] s = m_ptr[m_sel] + {8'h00, a};
        return {ex[23:16], s};
    endfunction

    // Apply one cycle: drive at negedge, check addresses, update model, check state.
    task automatic step(bit swr, logic [1:0] s, logic [2:0] c, logic [7:0] w,
                        logic [7:0] a, logic [23:0] ex);
        sel_wr = swr; sel = s; cmd = c; wdata = w; acc = a; exec_addr = ex;
        #1;
        chk("R6 data_addr", {8'h0, data_addr}, {8'h0, m_pg[m_sel], m_ptr[m_sel]});
        chk("R7 code_addr", {8'h0, code_addr}, {8'h0, exp_code(a, ex)});
        case (c)
            3'd1: m_ptr[m_sel][7:0]  = w;
            3'd2: m_ptr[m_sel][15:8] = w;
            3'd3: m_pg[m_sel]        = w;
            3'd4: m_ptr[m_sel]       = m_ptr[m_sel] + 16'd1;
            3'd5: m_ptr[m_sel]       = m_ptr[m_sel] - 16'd1;
            default: ;
        endcase
        if (swr) m_sel = s;
        @(posedge clk);
        @(negedge clk);
        chk("R2 sel", {30'h0, sel_o}, {30'h0, m_sel});
        chk("R3/R4/R5/R9 ptr", {16'h0, ptr_o}, {16'h0, m_ptr[m_sel]});
        chk("R3/R8/R9 page", {24'h0, page_o}, {24'h0, m_pg[m_sel]});
    endtask

    task automatic show_all();
        for (int p = 0; p < 4; p++) begin
            step(1'b1, 2'(p), 3'd0, 8'h00, 8'h00, 24'h000000);
            chk("R9 pair ptr", {16'h0, ptr_o}, {16'h0, m_ptr[p]});
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int p = 0; p < 4; p++) begin m_ptr[p] = '0; m_pg[p] = '0; end
        m_sel = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sel", {30'h0, sel_o}, 32'h0);
        chk("R1 data_addr", {8'h0, data_addr}, 32'h0);
        rst_n = 1'b1;
        show_all();

        // R3: byte writes on pair 2
        step(1'b1, 2'd2, 3'd0, 8'h00, 8'h00, 24'h0);
        step(1'b0, 2'd0, 3'd1, 8'hFF, 8'h00, 24'h0);
        step(1'b0, 2'd0, 3'd2, 8'hFF, 8'h00, 24'h0);
        step(1'b0, 2'd0, 3'd3, 8'h5A, 8'h00, 24'h0);
        chk("R3 data_addr", {8'h0, data_addr}, 32'h005AFFFF);
        // R4: increment wraps, page held
        step(1'b0, 2'd0, 3'd4, 8'h00, 8'h00, 24'h0);
        chk("R4 wrap", {8'h0, data_addr}, 32'h005A0000);
        // R5: decrement wraps, page held
        step(1'b0, 2'd0, 3'd5, 8'h00, 8'h00, 24'h0);
        chk("R5 wrap", {8'h0, data_addr}, 32'h005AFFFF);
        // R7: sum crosses bank boundary, page from execution address
        step(1'b0, 2'd0, 3'd1, 8'hF0, 8'h00, 24'h0);
        sel_wr = 0; cmd = 3'd0; acc = 8'h20; exec_addr = 24'h37ABCD;
        #1;
        chk("R7 bank wrap", {8'h0, code_addr}, 32'h00370010);
        // R8: idle codes
        step(1'b0, 2'd0, 3'd6, 8'h11, 8'h00, 24'h0);
        step(1'b0, 2'd0, 3'd7, 8'h22, 8'h00, 24'h0);
        chk("R8 idle", {8'h0, data_addr}, 32'h005AFFF0);
        show_all();

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) == 0, 2'($urandom), 3'($urandom), 8'($urandom),
                 8'($urandom), 24'($urandom));
        end
        show_all();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule